// File: doc/BRIEF.md
# DRAM Bank Precharge State Tracker

This block sits on the controller side of a DRAM interface and keeps the row state of every bank: open, closed and usable, or recovering from a precharge. The controller presents one decoded command per clock through a valid/ready handshake. A command carries an operation, a bank number and the auto-all flag that travels on address bit 10. The block moves the addressed bank or banks to their new state. It also raises a one-cycle error strobe when a command breaks the row rules: a column access to a bank that has no open row, or a row activation before the bank has finished recovering.

Precharge recovery is timed by a per-bank down-counter, with both recovery lengths given as parameters in controller clock cycles. A precharge aimed at one bank uses the short length. A precharge aimed at every bank uses the long length for all of them, whatever state each bank was in before. A new precharge to a bank that is still recovering restarts its timer with the length of the newer command. Two per-bank output vectors tell the scheduler which banks may be activated now and which hold an open row.

Top module: `bank_precharge_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bank reports ready and not open, `cmd_err` is low and `cmd_ready` is low.
- R2: An activate (`cmd_op` = 0) accepted for a bank whose ready bit is high opens that bank: from the next cycle its open bit is high, its ready bit is low and `cmd_err` stays low.
- R3: A read (`cmd_op` = 1) or write (`cmd_op` = 2) to an open bank changes no state and raises no error. The same command to a bank that is not open sets `cmd_err` high for exactly the next cycle and changes no state.
- R4: A precharge (`cmd_op` = 3) with `cmd_a10` low closes only the bank named by `cmd_bank`. That bank's ready bit is low until T_RP cycles after acceptance, so an activate presented exactly T_RP cycles after the precharge is legal. Other banks are unaffected.
- R5: A precharge with `cmd_a10` high ignores `cmd_bank` and closes every bank, whether open, idle or recovering. Every bank becomes ready again exactly T_RPA cycles after acceptance.
- R6: A precharge to a bank that is idle or still recovering is legal and never raises `cmd_err`.
- R7: When a bank receives a further precharge while recovering, its recovery is measured from the latest precharge, using that command's length (T_RP or T_RPA).
- R8: An activate to a bank that is open or still recovering sets `cmd_err` high for the next cycle and leaves every bank's open and ready state as it would have been without the command.
- R9: `cmd_ready` rises one cycle after reset release and stays high. A command is taken only when `cmd_valid` and `cmd_ready` are both high. With `cmd_valid` low, no bank changes state and `cmd_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The tracker accepts a command this cycle |
| cmd_op | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank; ignored for an all-bank precharge |
| cmd_a10 | input | 1 | On precharge: high selects all banks |
| bank_ready | output | NUM_BANKS | Bank may accept an activate this cycle |
| bank_open | output | NUM_BANKS | Bank holds an open row |
| cmd_err | output | 1 | Pulses the cycle after an illegal command |

## Verification
The hardest situation to reach is a bank that is hit by a second precharge part-way through its recovery, especially when one of the two precharges is short and the other is the all-bank kind. The recovery then has to be timed from the later command with the later length, and the outcome is only visible as the exact cycle in which an activate first becomes legal. The stimulus gets there by sweeping every operation, bank and flag combination with idle gaps from zero up to past the long recovery time. A long pseudo-random run follows, and a reference that records the cycle and length of each bank's latest precharge predicts readiness for every cycle.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } bpt_op_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_RECOVER = 2'd2
    } bpt_bank_e;

endpackage

// File: rtl/bpt_cmd_decode.sv
module bpt_cmd_decode
    import bpt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input  logic                 fire_i,
    input  logic [1:0]           op_i,
    input  logic [BA_W-1:0]      bank_i,
    input  logic                 a10_i,
    output logic [NUM_BANKS-1:0] act_o,
    output logic [NUM_BANKS-1:0] rw_o,
    output logic [NUM_BANKS-1:0] pre_o,
    output logic                 pre_all_o
);

    logic is_act, is_rw, is_pre;

    always_comb begin
        is_act    = fire_i && (op_i == OP_ACT);
        is_rw     = fire_i && ((op_i == OP_RD) || (op_i == OP_WR));
        is_pre    = fire_i && (op_i == OP_PRE);
        pre_all_o = is_pre && a10_i;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
        logic hit;
        assign hit      = (bank_i == BA_W'(g));
        assign act_o[g] = is_act && hit;
        assign rw_o[g]  = is_rw && hit;
        assign pre_o[g] = is_pre && (a10_i || hit);
    end

endmodule

// File: rtl/bpt_bank.sv
module bpt_bank
    import bpt_pkg::*;
#(
    parameter int T_RP  = 4,
    parameter int T_RPA = 6,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic rw_i,
    input  logic pre_i,
    input  logic pre_all_i,
    output logic ready_o,
    output logic open_o,
    output logic bad_o
);

    typedef struct packed {
        bpt_bank_e        st;
        logic [CNT_W-1:0] cnt;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        ready_o = (s_q.st == BK_IDLE) || ((s_q.st == BK_RECOVER) && (s_q.cnt == '0));
        open_o  = (s_q.st == BK_OPEN);
        bad_o   = (act_i && !ready_o) || (rw_i && !open_o);

        s_d = s_q;
        if (pre_i) begin
            s_d.st  = BK_RECOVER;
            s_d.cnt = pre_all_i ? CNT_W'(T_RPA - 1) : CNT_W'(T_RP - 1);
        end else if (act_i && ready_o) begin
            s_d.st  = BK_OPEN;
            s_d.cnt = '0;
        end else if (s_q.st == BK_RECOVER) begin
            if (s_q.cnt == '0) begin
                s_d.st = BK_IDLE;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: BK_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/bank_precharge_tracker.sv
module bank_precharge_tracker
    import bpt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RP      = 4,
    parameter int T_RPA     = 6,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_op,
    input  logic [BA_W-1:0]      cmd_bank,
    input  logic                 cmd_a10,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 cmd_err
);

    localparam int T_MAX = (T_RP > T_RPA) ? T_RP : T_RPA;
    localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    typedef struct packed {
        logic rdy;
        logic err;
    } top_t;

    top_t top_d, top_q;

    logic                 fire;
    logic [NUM_BANKS-1:0] act_sel, rw_sel, pre_sel, bad;
    logic                 pre_all;

    assign fire = cmd_valid && top_q.rdy;

    bpt_cmd_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W)
    ) u_decode (
        .fire_i    (fire),
        .op_i      (cmd_op),
        .bank_i    (cmd_bank),
        .a10_i     (cmd_a10),
        .act_o     (act_sel),
        .rw_o      (rw_sel),
        .pre_o     (pre_sel),
        .pre_all_o (pre_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bpt_bank #(
            .T_RP  (T_RP),
            .T_RPA (T_RPA),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act_sel[b]),
            .rw_i      (rw_sel[b]),
            .pre_i     (pre_sel[b]),
            .pre_all_i (pre_all),
            .ready_o   (bank_ready[b]),
            .open_o    (bank_open[b]),
            .bad_o     (bad[b])
        );
    end

    always_comb begin
        top_d     = top_q;
        top_d.rdy = 1'b1;
        top_d.err = |bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '{rdy: 1'b0, err: 1'b0};
        end else begin
            top_q <= top_d;
        end
    end

    assign cmd_ready = top_q.rdy;
    assign cmd_err   = top_q.err;

endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [1:0]           cmd_op,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 cmd_a10,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 cmd_err
);

    logic fire;
    assign fire = cmd_valid && cmd_ready;

    a_r9_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |=> cmd_ready);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !cmd_err);

    a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (cmd_op == 2'd0) && bank_ready[cmd_bank]
        |=> !cmd_err && bank_open[$past(cmd_bank)]);

    a_r2_open_excludes_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_open & bank_ready) == '0);

    a_r3_rw_closed_err: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (cmd_op == 2'd1 || cmd_op == 2'd2) && !bank_open[cmd_bank]
        |=> cmd_err);

    a_r3_rw_open_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (cmd_op == 2'd1 || cmd_op == 2'd2) && bank_open[cmd_bank]
        |=> !cmd_err && $stable(bank_open));

    a_r8_act_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (cmd_op == 2'd0) && !bank_ready[cmd_bank]
        |=> cmd_err && (bank_open == $past(bank_open)));

    a_r4_pre_one_closes: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (cmd_op == 2'd3) && !cmd_a10
        |=> !cmd_err && !bank_open[$past(cmd_bank)]);

    a_r5_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (cmd_op == 2'd3) && cmd_a10
        |=> !cmd_err && (bank_open == '0));

endmodule

bind bank_precharge_tracker bpt_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .cmd_a10    (cmd_a10),
    .bank_ready (bank_ready),
    .bank_open  (bank_open),
    .cmd_err    (cmd_err)
);

// File: tb/test_bank_precharge_tracker.sv
module test_bank_precharge_tracker;

    localparam int NB   = 4;
    localparam int TRP  = 3;
    localparam int TRPA = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic [1:0]    cmd_bank = 2'd0;
    logic          cmd_a10 = 1'b0;
    logic [NB-1:0] bank_ready;
    logic [NB-1:0] bank_open;
    logic          cmd_err;

    always #4 clk = ~clk;

    bank_precharge_tracker #(
        .NUM_BANKS (NB),
        .T_RP      (TRP),
        .T_RPA     (TRPA)
    ) i_bank_precharge_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_bank   (cmd_bank),
        .cmd_a10    (cmd_a10),
        .bank_ready (bank_ready),
        .bank_open  (bank_open),
        .cmd_err    (cmd_err)
    );

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;
    bit mdl_open [NB];
    int pre_at   [NB];
    int pre_len  [NB];
    logic [15:0] lfsr = 16'hACE1;

    function automatic bit mdl_ready(int b, int e);
        return !mdl_open[b] && (e >= pre_at[b] + pre_len[b]);
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(bit v, bit [1:0] op, int b, bit a10, string tag_in);
        bit    exp_err;
        string tag;
        logic [NB-1:0] exp_open, exp_rdy;
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = op;
        cmd_bank  = 2'(b);
        cmd_a10   = a10;
        @(posedge clk);
        edge_n++;
        exp_err = 1'b0;
        tag = tag_in;
        if (!v) begin
            if (tag == "") tag = "R9";
        end else begin
            case (op)
                2'd0: begin
                    if (mdl_ready(b, edge_n)) begin
                        mdl_open[b] = 1'b1;
                        if (tag == "") tag = "R2";
                    end else begin
                        exp_err = 1'b1;
                        if (tag == "") tag = "R8";
                    end
                end
                2'd1, 2'd2: begin
                    if (!mdl_open[b]) exp_err = 1'b1;
                    if (tag == "") tag = "R3";
                end
                default: begin
                    if (tag == "") begin
                        if (!a10 && !mdl_open[b]) tag = "R6";
                        else tag = a10 ? "R5" : "R4";
                    end
                    for (int k = 0; k < NB; k++) begin
                        if (a10 || k == b) begin
                            mdl_open[k] = 1'b0;
                            pre_at[k]   = edge_n;
                            pre_len[k]  = a10 ? TRPA : TRP;
                        end
                    end
                end
            endcase
        end
        #2;
        for (int k = 0; k < NB; k++) begin
            exp_open[k] = mdl_open[k];
            exp_rdy[k]  = mdl_ready(k, edge_n + 1);
        end
        chk(tag, "cmd_err", int'(cmd_err), int'(exp_err));
        chk(tag, "bank_open", int'(bank_open), int'(exp_open));
        chk(tag, "bank_ready", int'(bank_ready), int'(exp_rdy));
        chk("R9", "cmd_ready", int'(cmd_ready), 1);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 0, 1'b0, tag);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NB; k++) begin
            mdl_open[k] = 1'b0;
            pre_at[k]   = -100;
            pre_len[k]  = 0;
        end
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values
        chk("R1", "bank_ready", int'(bank_ready), (1 << NB) - 1);
        chk("R1", "bank_open", int'(bank_open), 0);
        chk("R1", "cmd_err", int'(cmd_err), 0);
        chk("R1", "cmd_ready", int'(cmd_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "cmd_ready", int'(cmd_ready), 0);
        idle(2, "R9");

        // directed sequence
        step(1'b1, 2'd0, 0, 1'b0, "R2");
        step(1'b1, 2'd1, 0, 1'b0, "R3");
        step(1'b1, 2'd2, 1, 1'b0, "R3");
        step(1'b1, 2'd0, 0, 1'b0, "R8");
        step(1'b1, 2'd3, 0, 1'b0, "R4");
        step(1'b1, 2'd0, 0, 1'b0, "R8");
        idle(TRP - 2, "R4");
        step(1'b1, 2'd0, 0, 1'b0, "R4");
        step(1'b1, 2'd0, 3, 1'b0, "R2");
        step(1'b1, 2'd3, 2, 1'b1, "R5");
        step(1'b1, 2'd3, 1, 1'b0, "R6");
        idle(TRPA, "R5");
        // R7: short then long restart, long then short restart
        step(1'b1, 2'd3, 2, 1'b0, "R7");
        idle(1, "R7");
        step(1'b1, 2'd3, 0, 1'b1, "R7");
        for (int i = 0; i < TRPA + 1; i++) step(1'b1, 2'd0, 2, 1'b0, "R7");
        step(1'b1, 2'd3, 1, 1'b1, "R7");
        idle(2, "R7");
        step(1'b1, 2'd3, 1, 1'b0, "R7");
        for (int i = 0; i < TRP + 1; i++) step(1'b1, 2'd0, 1, 1'b0, "R7");
        // R9: no valid, activate fields on a ready bank
        step(1'b0, 2'd0, 3, 1'b0, "R9");
        step(1'b0, 2'd3, 1, 1'b1, "R9");

        // sweep of every command with every gap length
        for (int gap = 0; gap <= TRPA + 1; gap++) begin
            for (int op = 0; op < 4; op++) begin
                for (int b = 0; b < NB; b++) begin
                    for (int a = 0; a < 2; a++) begin
                        step(1'b1, 2'(op), b, 1'(a), "");
                        idle(gap, "");
                    end
                end
            end
        end

        // pseudo-random run
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr[3:2], int'(lfsr[5:4]),
                 lfsr[6] & lfsr[7] & lfsr[8], "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule